// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation converter. A control register holds an enable bit, a start/busy bit, a two-bit input channel select and a two-bit bit-time select. Writing the start bit while the converter is enabled launches a conversion. The block then drives a trial code to an external DAC and comparator. It samples the single comparator answer once per bit-time and settles one result bit per bit-time, from the MSB down.

The channel that feeds the analog front end is frozen for the length of a conversion. A new selection written during that time takes effect once the conversion ends. Clearing the enable bit, or entering sleep, abandons a running conversion without touching the stored result. Sleep also discards the channel selection.

Top module: `sar_seq`

## Requirements
- R1: After reset the enable bit is 0, busy is 0, the channel select is 2'b11, the bit-time select is 2'b00 and the result is 0.
- R2: A write with wr_en_i=1 and wr_go_i=1 while idle sets busy_o on the following cycle and presents trial code 0x80.
- R3: On each bit-time the trial bit under test is kept when cmp_i=1 (input at or above trial) and cleared when cmp_i=0, and the next lower bit is set. With an ideal comparator the final result equals the input code.
- R4: One bit-time lasts 2^(1+sel) clocks, where sel is the bit-time select. busy_o clears, and result_o holds the new code, exactly 8 bit-times after the start write edge.
- R5: A start written together with wr_en_i=0 does not start a conversion, and the enable bit reads back 0.
- R6: A start written while busy has no effect: the running conversion ends at its original time with the correct result.
- R7: chan_act_o stays at the channel given at start for the whole conversion. A channel written meanwhile shows on chan_sel_o at once and on chan_act_o from the cycle busy clears.
- R8: A write with wr_en_i=0 during a conversion clears busy on that edge, and result_o keeps its previous value.
- R9: sleep_i high aborts any conversion and forces the channel select to 2'b11. result_o keeps its value.
- R10: result_o changes only on the edge that completes a conversion.
- R11: The bit-time select is captured at start. Rewriting it during a conversion does not change that conversion's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_i | input | 1 | Sleep entry: abort and drop channel select |
| wr_i | input | 1 | Control register write strobe |
| wr_en_i | input | 1 | Enable bit write value |
| wr_go_i | input | 1 | Start bit write value |
| wr_chan_i | input | 2 | Channel select write value |
| wr_clk_i | input | 2 | Bit-time select write value |
| cmp_i | input | 1 | Comparator answer, 1 when input >= trial |
| busy_o | output | 1 | Start/busy bit, clears at completion |
| en_o | output | 1 | Enable bit |
| chan_sel_o | output | 2 | Channel select as written |
| clk_sel_o | output | 2 | Bit-time select as written |
| chan_act_o | output | 2 | Channel routed to the analog front end |
| trial_o | output | 8 | Trial code to the DAC |
| result_o | output | 8 | Last completed result |

## Verification
A start write sampled at edge E makes busy_o and trial 0x80 visible right after E. The first trial update lands at E plus one bit-time. Completion lands at E plus 8 bit-times, and an abort or sleep takes effect on its own edge. The bench drives each write at a falling edge and then counts falling edges from the start write. It checks busy still high one sample before the due edge and the result one sample after it. Mid-conversion writes are included in that count, so every check lands on the cycle the requirement predicts.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned CHAN_W = 2;
  localparam int unsigned TSEL_W = 2;
  localparam logic [CHAN_W-1:0] CHAN_RST = '1;
endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
  parameter int unsigned BASE_LOG = 1,
  parameter int unsigned SEL_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = BASE_LOG + (1 << SEL_W) - 1;
  localparam logic [SEL_W-1:0] SH_MAX = SEL_W'((1 << SEL_W) - 1);

  logic [CNT_W-1:0] cnt_q, lim;

  assign lim    = {CNT_W{1'b1}} >> (SH_MAX - sel_i);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i || tick_o) cnt_q <= '0;
    else if (run_i)             cnt_q <= cnt_q + 1'b1;
  end

  // R4: a bit-time is never shorter than two clocks
  a_r4_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int unsigned RES_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] final_o,
  output logic             last_o
);
  localparam logic [RES_W-1:0] MSB = RES_W'(1) << (RES_W - 1);

  logic [RES_W-1:0] trial_q, mask_q, kept;

  // comparator decides the bit under test
  assign kept    = cmp_i ? trial_q : (trial_q & ~mask_q);
  assign final_o = kept;
  assign last_o  = mask_q[0];
  assign trial_o = trial_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trial_q <= '0;
      mask_q  <= '0;
    end else if (start_i) begin
      trial_q <= MSB;
      mask_q  <= MSB;
    end else if (tick_i) begin
      trial_q <= kept | (mask_q >> 1);
      mask_q  <= mask_q >> 1;
    end
  end

  a_r3_one_bit_under_test: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mask_q));
  a_r2_start_loads_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (trial_q == MSB));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
#(
  parameter int unsigned RES_W    = 8,
  parameter int unsigned BASE_LOG = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic              wr_i,
  input  logic              wr_en_i,
  input  logic              wr_go_i,
  input  logic [CHAN_W-1:0] wr_chan_i,
  input  logic [TSEL_W-1:0] wr_clk_i,
  input  logic              cmp_i,
  output logic              busy_o,
  output logic              en_o,
  output logic [CHAN_W-1:0] chan_sel_o,
  output logic [TSEL_W-1:0] clk_sel_o,
  output logic [CHAN_W-1:0] chan_act_o,
  output logic [RES_W-1:0]  trial_o,
  output logic [RES_W-1:0]  result_o
);
  logic              en_q, busy_q;
  logic [CHAN_W-1:0] chan_sel_q, chan_hold_q;
  logic [TSEL_W-1:0] clk_sel_q, clk_hold_q;
  logic [RES_W-1:0]  result_q, final_code;
  logic              start, abort, done, tick, last;

  // start is locked out unless the written enable is set and the engine idle
  assign start = wr_i && wr_en_i && wr_go_i && !busy_q && !sleep_i;
  assign abort = sleep_i || (wr_i && !wr_en_i);
  assign done  = busy_q && tick && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      chan_sel_q <= CHAN_RST;
      clk_sel_q  <= '0;
    end else if (sleep_i) begin
      chan_sel_q <= CHAN_RST;
    end else if (wr_i) begin
      en_q       <= wr_en_i;
      chan_sel_q <= wr_chan_i;
      clk_sel_q  <= wr_clk_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    busy_q <= 1'b0;
    else if (abort) busy_q <= 1'b0;
    else if (start) busy_q <= 1'b1;
    else if (done)  busy_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_hold_q <= CHAN_RST;
      clk_hold_q  <= '0;
    end else if (start) begin
      chan_hold_q <= wr_chan_i;
      clk_hold_q  <= wr_clk_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             result_q <= '0;
    else if (done && !abort) result_q <= final_code;
  end

  sar_clkdiv #(.BASE_LOG(BASE_LOG), .SEL_W(TSEL_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start),
    .run_i   (busy_q),
    .sel_i   (clk_hold_q),
    .tick_o  (tick)
  );

  sar_engine #(.RES_W(RES_W)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .tick_i  (tick),
    .cmp_i   (cmp_i),
    .trial_o (trial_o),
    .final_o (final_code),
    .last_o  (last)
  );

  assign busy_o     = busy_q;
  assign en_o       = en_q;
  assign chan_sel_o = chan_sel_q;
  assign clk_sel_o  = clk_sel_q;
  assign chan_act_o = busy_q ? chan_hold_q : chan_sel_q;
  assign result_o   = result_q;

  a_r5_busy_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> en_q);
  a_r10_result_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(result_q));
  a_r7_chan_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> (!busy_q || $stable(chan_act_o)));
  a_r11_tsel_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> (!busy_q || $stable(clk_hold_q)));
  a_r9_sleep_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> (!busy_q && chan_sel_q == CHAN_RST));
  a_r8_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !wr_en_i) |=> !busy_q);
endmodule

// File: tb/sar_seq_tb.sv
module sar_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sleep = 1'b0;
  logic       wr = 1'b0, wr_en = 1'b0, wr_go = 1'b0;
  logic [1:0] wr_chan = 2'b00, wr_clk = 2'b00;
  logic       cmp;
  logic       busy, en;
  logic [1:0] chan_sel, clk_sel, chan_act;
  logic [7:0] trial, result;
  logic [7:0] vin [4];

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural DAC + comparator
  assign cmp = (vin[chan_act] >= trial);

  sar_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sleep_i(sleep),
    .wr_i(wr), .wr_en_i(wr_en), .wr_go_i(wr_go), .wr_chan_i(wr_chan), .wr_clk_i(wr_clk),
    .cmp_i(cmp), .busy_o(busy), .en_o(en), .chan_sel_o(chan_sel), .clk_sel_o(clk_sel),
    .chan_act_o(chan_act), .trial_o(trial), .result_o(result)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; write lands on the next rising edge
  task automatic wr_ctrl(input logic e, input logic g, input logic [1:0] c, input logic [1:0] t);
    wr = 1'b1; wr_en = e; wr_go = g; wr_chan = c; wr_clk = t;
    @(negedge clk);
    wr = 1'b0; wr_go = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 busy", busy, 0);
    chk("R1 en", en, 0);
    chk("R1 chan", chan_sel, 2'b11);
    chk("R1 clksel", clk_sel, 0);
    chk("R1 result", result, 0);
  endtask

  task automatic t_conv(input logic [1:0] c, input logic [1:0] t);
    int div = 2 << t;
    wr_ctrl(1, 1, c, t);
    chk("R2 busy", busy, 1);
    chk("R2 trial", trial, 8'h80);
    repeat (div) @(negedge clk);
    chk("R3 first step", trial, (vin[c] >= 8'h80) ? 8'hC0 : 8'h40);
    repeat (7*div - 1) @(negedge clk);
    chk("R4 busy before due", busy, 1);
    @(negedge clk);
    chk("R4 busy cleared", busy, 0);
    chk("R3 result", result, vin[c]);
  endtask

  task automatic t_lockout;
    logic [7:0] prev = result;
    wr_ctrl(0, 1, 2'b00, 2'b00);
    chk("R5 no start", busy, 0);
    chk("R5 en", en, 0);
    wr_ctrl(0, 1, 2'b01, 2'b00);
    repeat (20) @(negedge clk);
    chk("R5 still idle", busy, 0);
    chk("R5 result", result, prev);
  endtask

  task automatic t_restart_busy;
    wr_ctrl(1, 1, 2'b00, 2'b01);
    repeat (10) @(negedge clk);
    wr_ctrl(1, 1, 2'b00, 2'b01);
    repeat (32 - 12) @(negedge clk);
    chk("R6 busy before due", busy, 1);
    @(negedge clk);
    chk("R6 done on time", busy, 0);
    chk("R6 result", result, vin[0]);
  endtask

  task automatic t_chan_defer;
    wr_ctrl(1, 1, 2'b01, 2'b00);
    repeat (5) @(negedge clk);
    wr_ctrl(1, 0, 2'b10, 2'b00);
    chk("R7 sel visible", chan_sel, 2'b10);
    chk("R7 act held", chan_act, 2'b01);
    repeat (16 - 7) @(negedge clk);
    chk("R7 act held late", chan_act, 2'b01);
    @(negedge clk);
    chk("R7 busy done", busy, 0);
    chk("R7 result old chan", result, vin[1]);
    chk("R7 act switched", chan_act, 2'b10);
  endtask

  task automatic t_tsel_capture;
    wr_ctrl(1, 1, 2'b11, 2'b11);
    repeat (20) @(negedge clk);
    wr_ctrl(1, 0, 2'b11, 2'b00);
    chk("R11 sel visible", clk_sel, 0);
    repeat (128 - 22) @(negedge clk);
    chk("R11 busy before due", busy, 1);
    @(negedge clk);
    chk("R11 done", busy, 0);
    chk("R11 result", result, vin[3]);
  endtask

  task automatic t_abort;
    logic [7:0] prev = result;
    wr_ctrl(1, 1, 2'b10, 2'b00);
    repeat (4) @(negedge clk);
    chk("R10 no mid update", result, prev);
    wr_ctrl(0, 0, 2'b10, 2'b00);
    chk("R8 busy cleared", busy, 0);
    chk("R8 result kept", result, prev);
    repeat (20) @(negedge clk);
    chk("R8 result still kept", result, prev);
  endtask

  task automatic t_sleep;
    logic [7:0] prev = result;
    wr_ctrl(1, 1, 2'b01, 2'b00);
    repeat (3) @(negedge clk);
    sleep = 1'b1;
    @(negedge clk);
    sleep = 1'b0;
    chk("R9 busy cleared", busy, 0);
    chk("R9 chan dropped", chan_sel, 2'b11);
    chk("R9 act", chan_act, 2'b11);
    chk("R9 result kept", result, prev);
  endtask

  initial begin
    vin[0] = 8'h00; vin[1] = 8'h5A; vin[2] = 8'hFF; vin[3] = 8'hA5;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_conv(2'b01, 2'b00);
    t_conv(2'b10, 2'b01);
    t_conv(2'b00, 2'b11);
    vin[3] = 8'h01;
    t_conv(2'b11, 2'b00);
    vin[3] = 8'hA5;
    t_lockout();
    t_restart_busy();
    t_chan_defer();
    t_tsel_capture();
    t_abort();
    t_sleep();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule